// File: doc/BRIEF.md
# Hardware Cursor Register Bank

This block holds the five programmable registers that steer a display controller's hardware cursor. The registers are the cursor image offset, the screen position, the hotspot offset, and two colours. A simple register bus reaches them. Each access carries a byte address, a size code, write data and a read or write strobe. Software may touch any register with 1, 2 or 4 byte accesses at any byte offset inside the register word. A narrow write merges into the bytes already held, so a register can be built up from several partial writes.

A single update-lock flag is stored in bit 31 of the offset register. The position and hotspot registers show that flag as their own bit 31 and can also change it. Toward the cursor renderer the block produces two outputs. The first is a one-cycle redefine pulse that asks for the cursor image to be rebuilt. The second is a one-cycle position-update pulse. The current horizontal and vertical position are driven out at all times.

Register index is taken from address bits 4:2:

| Index | Register |
|---|---|
| 0 | offset |
| 1 | position |
| 2 | hotspot |
| 3 | colour A |
| 4 | colour B |

Address bits 1:0 select the starting byte.

Top module: `cursor_regfile`

## Requirements
- R1: A write of size code 0 (1 byte), 1 (2 bytes) or 2/3 (4 bytes) at byte offset b replaces only register bytes b upward, taking them from `wdata` starting at bit 0. Bytes past byte 3 are dropped, and all other bytes keep their value.
- R2: After each merge a register keeps only its own bits:
  - offset: 0x87FFFFF0
  - position: 0x3FFF0FFF
  - hotspot: 0x003F003F
  - colour A and colour B: 0x00FFFFFF
- R3: A read returns the addressed bytes shifted down to bit 0, with all higher bits zero. `rdata` is loaded at the clock edge that samples `rd_en`, returns the contents from before any write in that same cycle, and otherwise holds its value.
- R4: Reads of the position and hotspot registers show the lock flag as bit 31. A narrow read therefore carries it only when it covers byte 3, at bit 31-8*offset.
- R5: A position or hotspot write is merged with the lock flag standing in bit 31. If the merged bit 31 is 1, the flag is set. If it is 0, the flag is cleared, and if the flag was set before, a redefine pulse follows.
- R6: A write to the offset or colour A register pulses redefine only when the masked value differs from the stored one.
- R7: Every write to the colour B register pulses redefine, even when the value is unchanged.
- R8: A position write pulses `pos_upd` only if `cur_en` is high and the merged bit 31 is 0. `pos_x` always carries position bits 29:16 and `pos_y` bits 11:0.
- R9: All registers, the lock flag, `rdata` and both pulses are zero after reset. Each pulse is high for exactly the one cycle after the write edge.
- R10: Accesses at byte addresses 20 and above write nothing, cause no pulse and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| wdata | input | 32 | Write data, aligned to bit 0 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| cur_en | input | 1 | Cursor enable, gates the position-update pulse |
| rdata | output | 32 | Registered read data |
| redefine | output | 1 | One-cycle request to rebuild the cursor image |
| pos_upd | output | 1 | One-cycle position-update pulse |
| pos_x | output | 14 | Horizontal cursor position |
| pos_y | output | 12 | Vertical cursor position |

## Verification
Every result of an access appears one clock after the rising edge that samples the strobe:
- `rdata`
- both pulses
- the new `pos_x` and `pos_y`

The bench drives each access on a falling edge and lets one rising edge pass. At the next falling edge it compares all five outputs against a behavioural byte-lane model that was advanced for that same cycle. Idle cycles are compared the same way, which shows that each pulse drops after a single cycle and that `rdata` holds its value between reads.

// File: rtl/cursor_regfile.sv
module cursor_regfile #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              cur_en,
  output logic [31:0]       rdata,
  output logic              redefine,
  output logic              pos_upd,
  output logic [13:0]       pos_x,
  output logic [11:0]       pos_y
);
  localparam logic [31:0] OFS_MASK = 32'h87FF_FFF0;
  localparam logic [31:0] POS_MASK = 32'h3FFF_0FFF;
  localparam logic [31:0] HOT_MASK = 32'h003F_003F;
  localparam logic [31:0] CLR_MASK = 32'h00FF_FFFF;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(5 * 4);

  logic [31:0] ofs_q, pos_q, hot_q, clra_q, clrb_q;
  logic [31:0] ofs_n, pos_n, hot_n, clra_n, clrb_n;
  logic [31:0] view, lane, wmask, merged;
  logic        red_n, upd_n;

  wire       hit = addr < LIMIT;
  wire [2:0] sel = addr[4:2];
  wire [4:0] bsh = {addr[1:0], 3'b000};

  assign lane   = (size == 2'd0) ? 32'h0000_00FF :
                  (size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign wmask  = lane << bsh;
  assign merged = (view & ~wmask) | ((wdata << bsh) & wmask);
  assign pos_x  = pos_q[29:16];
  assign pos_y  = pos_q[11:0];

  always_comb begin
    case (sel)
      3'd0:    view = ofs_q;
      3'd1:    view = {ofs_q[31], pos_q[30:0]};
      3'd2:    view = {ofs_q[31], hot_q[30:0]};
      3'd3:    view = clra_q;
      3'd4:    view = clrb_q;
      default: view = '0;
    endcase
  end

  always_comb begin
    ofs_n  = ofs_q;
    pos_n  = pos_q;
    hot_n  = hot_q;
    clra_n = clra_q;
    clrb_n = clrb_q;
    red_n  = 1'b0;
    upd_n  = 1'b0;
    if (wr_en && hit) begin
      case (sel)
        3'd0: begin
          ofs_n = merged & OFS_MASK;
          red_n = ofs_n != ofs_q;
        end
        3'd1, 3'd2: begin
          if (sel == 3'd1) pos_n = merged & POS_MASK;
          else             hot_n = merged & HOT_MASK;
          ofs_n[31] = merged[31];
          red_n     = !merged[31] && ofs_q[31];
          upd_n     = (sel == 3'd1) && cur_en && !merged[31];
        end
        3'd3: begin
          clra_n = merged & CLR_MASK;
          red_n  = clra_n != clra_q;
        end
        3'd4: begin
          clrb_n = merged & CLR_MASK;
          red_n  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q    <= '0;
      pos_q    <= '0;
      hot_q    <= '0;
      clra_q   <= '0;
      clrb_q   <= '0;
      rdata    <= '0;
      redefine <= 1'b0;
      pos_upd  <= 1'b0;
    end else begin
      ofs_q    <= ofs_n;
      pos_q    <= pos_n;
      hot_q    <= hot_n;
      clra_q   <= clra_n;
      clrb_q   <= clrb_n;
      redefine <= red_n;
      pos_upd  <= upd_n;
      if (rd_en) rdata <= hit ? ((view >> bsh) & lane) : '0;
    end
  end
endmodule

// File: rtl/cursor_regfile_chk.sv
module cursor_regfile_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic              wr_en,
  input logic              rd_en,
  input logic              cur_en,
  input logic [31:0]       rdata,
  input logic              redefine,
  input logic              pos_upd,
  input logic [13:0]       pos_x,
  input logic [11:0]       pos_y
);
  assert_redef_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redefine |-> $past(wr_en));
  assert_upd_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pos_upd |-> $past(wr_en && cur_en));
  assert_pos_stable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pos_x) && $stable(pos_y));
  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  assert_byte_read_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && size == 2'd0 |=> rdata[31:8] == 24'd0);
  assert_colb_redef_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr >= ADDR_W'(16) && addr < ADDR_W'(20) |=> redefine);
  assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr >= ADDR_W'(20) |=> !redefine && !pos_upd);
endmodule

bind cursor_regfile cursor_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cursor_regfile_test.sv
module cursor_regfile_test;
  localparam logic [31:0] OFS_M = 32'h87FF_FFF0, POS_M = 32'h3FFF_0FFF;
  localparam logic [31:0] HOT_M = 32'h003F_003F, CLR_M = 32'h00FF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic [1:0] size = '0;
  logic [31:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, cur_en = 1'b0;
  logic [31:0] rdata;
  logic redefine, pos_upd;
  logic [13:0] pos_x;
  logic [11:0] pos_y;

  int compared = 0, mismatched = 0, cyc = 0;
  logic [31:0] m [5];
  logic [31:0] e_rd;
  logic e_red, e_upd;

  always #10 clk = ~clk;

  cursor_regfile uut (.clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .cur_en(cur_en), .rdata(rdata), .redefine(redefine),
    .pos_upd(pos_upd), .pos_x(pos_x), .pos_y(pos_y));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [31:0] mview(int i);
    logic [31:0] v = m[i];
    if (i == 1 || i == 2) v[31] = m[0][31];
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(bit wr, bit rd, int a, int sz, logic [31:0] d);
    int idx = a / 4, b = a % 4;
    int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    logic [31:0] v, nv;
    e_red = 1'b0;
    e_upd = 1'b0;
    if (rd) begin
      e_rd = '0;
      if (idx < 5) begin
        v = mview(idx);
        for (int k = 0; k < nb; k++)
          if (b + k < 4) e_rd[8*k +: 8] = v[8*(b+k) +: 8];
      end
    end
    if (wr && idx < 5) begin
      v = mview(idx);
      for (int k = 0; k < nb; k++)
        if (b + k < 4) v[8*(b+k) +: 8] = d[8*k +: 8];
      case (idx)
        0: begin nv = v & OFS_M; e_red = nv != m[0]; m[0] = nv; end
        3: begin nv = v & CLR_M; e_red = nv != m[3]; m[3] = nv; end
        4: begin m[4] = v & CLR_M; e_red = 1'b1; end
        default: begin
          m[idx] = v & ((idx == 1) ? POS_M : HOT_M);
          if (!v[31] && m[0][31]) e_red = 1'b1;
          m[0][31] = v[31];
          if (idx == 1 && cur_en && !v[31]) e_upd = 1'b1;
        end
      endcase
    end
  endtask

  task automatic step(string tag, bit wr, bit rd, int a, int sz, logic [31:0] d);
    wr_en = wr; rd_en = rd; addr = a[4:0]; size = sz[1:0]; wdata = d;
    model(wr, rd, a, sz, d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(tag, "rdata", rdata, e_rd);
    chk(tag, "redefine", {31'd0, redefine}, {31'd0, e_red});
    chk(tag, "pos_upd", {31'd0, pos_upd}, {31'd0, e_upd});
    chk(tag, "pos_x", {18'd0, pos_x}, {18'd0, m[1][29:16]});
    chk(tag, "pos_y", {20'd0, pos_y}, {20'd0, m[1][11:0]});
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 1'b0, 0, 0, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) m[i] = '0;
    e_rd = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle("R9 reset");
    for (int i = 0; i < 20; i += 4) step("R9 reset read", 0, 1, i, 2, 0);

    cur_en = 1'b1;
    step("R1 pos byte0", 1, 0, 4, 0, 32'hAAAA_AA34);
    step("R1 pos byte1", 1, 0, 5, 0, 32'h0000_0002);
    step("R1 pos byte2", 1, 0, 6, 0, 32'h0000_0055);
    step("R1 pos byte3", 1, 0, 7, 0, 32'h0000_0011);
    step("R1 pos read", 0, 1, 4, 2, 0);
    idle("R9 pulse drop");
    step("R1 ofs half hi", 1, 0, 2, 1, 32'h0000_1234);
    step("R1 ofs half lo", 1, 0, 0, 1, 32'h0000_ABCD);
    step("R1 ofs read", 0, 1, 0, 2, 0);
    step("R1 cross drop", 1, 0, 3, 2, 32'h7766_5544);
    step("R1 cross read", 0, 1, 0, 2, 0);

    for (int i = 0; i < 5; i++) begin
      step("R2 all ones", 1, 0, i * 4, 2, 32'h7FFF_FFFF);
      step("R2 read mask", 0, 1, i * 4, 2, 0);
    end
    step("R3 byte1", 0, 1, 13, 0, 0);
    step("R3 half2", 0, 1, 14, 1, 0);
    idle("R3 hold");
    step("R3 read old on write", 1, 1, 12, 2, 32'h0012_3456);
    step("R3 read new", 0, 1, 12, 2, 0);

    step("R4 set via ofs", 1, 0, 3, 0, 32'h0000_0080);
    step("R4 pos full", 0, 1, 4, 2, 0);
    step("R4 hot byte3", 0, 1, 11, 0, 0);
    step("R4 hot half2", 0, 1, 10, 1, 0);
    step("R4 pos byte0", 0, 1, 4, 0, 0);
    step("R8 locked pos", 1, 0, 4, 0, 32'h0000_0021);
    step("R5 hot clear", 1, 0, 11, 0, 32'h0000_0000);
    step("R5 read ofs", 0, 1, 0, 2, 0);
    step("R5 hot set", 1, 0, 8, 2, 32'h8001_0002);
    step("R5 set again", 1, 0, 9, 0, 32'h0000_0000);
    step("R5 pos clear", 1, 0, 4, 2, 32'h0040_0100);

    step("R6 ofs new", 1, 0, 0, 2, 32'h0000_1000);
    step("R6 ofs same", 1, 0, 0, 2, 32'h0000_1000);
    step("R6 ofs masked same", 1, 0, 0, 0, 32'h0000_0005);
    step("R6 clra new", 1, 0, 12, 2, 32'h0011_2233);
    step("R6 clra same", 1, 0, 12, 2, 32'hFF11_2233);
    step("R7 clrb", 1, 0, 16, 2, 32'h0000_0042);
    step("R7 clrb same", 1, 0, 16, 2, 32'h0000_0042);

    cur_en = 1'b0;
    step("R8 disabled", 1, 0, 4, 2, 32'h0123_0456);
    cur_en = 1'b1;
    step("R8 enabled", 1, 0, 6, 1, 32'h0200);
    step("R8 lock set", 1, 0, 7, 0, 32'h0000_0080);

    step("R10 write", 1, 0, 24, 2, 32'hFFFF_FFFF);
    step("R10 read", 0, 1, 20, 2, 0);
    for (int i = 0; i < 20; i += 4) step("R10 no change", 0, 1, i, 2, 0);
    idle("R9 end");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule